// File: doc/BRIEF.md
# Pipelined Newton-Raphson Significand Divider

This block divides one normalized significand by another and returns a normalized 24-bit quotient. Both operands are unsigned values of the form 1.f, where f has 23 bits. The quotient of two such values lies in (0.5, 2). When it falls below one, the block shifts it up by one place and raises a flag, so that the caller can decrement the exponent. The block takes a new operand pair on every clock. Each result appears a fixed five edges after its operands are taken.

The reciprocal of the divisor starts from a seed. A small table, built at elaboration and indexed by the six leading fraction bits of the divisor, holds the first Taylor term rounded upward. The seed is that entry times a modified copy of the divisor: the indexed bits are kept and the next nine bits are inverted. One refinement step of the form 2x − D·x² then yields a reciprocal with 27 fraction bits. The square of the seed is truncated to 27 fraction bits. Its product with D is rounded to 27 fraction bits. The refined reciprocal is multiplied by the dividend and rounded to the output width.

Top module: `nr_sig_div`

## Requirements
- R1: When num_i ≥ den_i (excluding the near-unity band of R8), lt_one_o is 0 and quo_o encodes the quotient with 23 fraction bits, so that |quo_o·den_i − num_i·2^23| ≤ den_i (at most one unit in the last place).
- R2: When num_i < den_i (excluding the near-unity band of R8), lt_one_o is 1 and quo_o holds the quotient doubled with 23 fraction bits (the quotient itself with 24 fraction bits), so that |quo_o·den_i − num_i·2^24| ≤ den_i.
- R3: Whenever out_valid is 1, bit 23 of quo_o is 1.
- R4: The result for operands taken at a rising edge with in_valid high appears with out_valid high right after the fifth rising edge, counting the taking edge as the first.
- R5: Operands offered on consecutive cycles all produce results, one per clock, in the order they were given.
- R6: A cycle with in_valid low produces no result: out_valid stays low five edges later, and the number of results equals the number of accepted operand pairs.
- R7: While rst_n is low, and after its release until the first result is due, out_valid is 0.
- R8: When num_i and den_i differ by at most one, either flag value may be returned, but quo_o must lie within one unit in the last place of the true quotient under the scale that lt_one_o selects (2^23 when 0, 2^24 when 1).
- R9: R1 and R2 hold for divisors in every one of the 64 seed segments, selected by bits 22 down to 17 of den_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| num_i | input | 24 | Dividend significand 1.f |
| den_i | input | 24 | Divisor significand 1.f |
| out_valid | output | 1 | Result present this cycle |
| quo_o | output | 24 | Normalized quotient significand |
| lt_one_o | output | 1 | Quotient was below one and has been doubled |

## Verification
Each accepted pair must produce its result exactly five rising edges after it is taken. The bench stamps every pair with the cycle count at the falling edge where it is driven. It compares each result with the oldest outstanding stamp at the falling edge where out_valid is seen. A result seen at any other count, a result with no pending pair, and a pair whose due cycle passes without a result are each reported against R4 or R6. Values are checked against an exact integer cross-multiplication, not against a copy of the datapath.

// File: rtl/nr_sig_div.sv
module nr_sig_div #(
  parameter int SIG_W    = 24,
  parameter int TAB_BITS = 6,
  parameter int TAB_W    = 15,
  parameter int MOD_W    = 15,
  parameter int SEED_F   = 16,
  parameter int DP_F     = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SIG_W-1:0] num_i,
  input  logic [SIG_W-1:0] den_i,
  output logic             out_valid,
  output logic [SIG_W-1:0] quo_o,
  output logic             lt_one_o
);
  localparam int F     = SIG_W - 1;
  localparam int TAB_N = 1 << TAB_BITS;
  localparam int INV_W = MOD_W - TAB_BITS;
  localparam int PRD_F = TAB_W + MOD_W;
  localparam int SQ_F  = 2 * SEED_F;
  localparam int PW    = DP_F + 1 + SIG_W;
  localparam int FIN_F = DP_F + F;

  // first Taylor term 1/(x1 + half segment)^2, rounded up
  function automatic logic [TAB_W-1:0] seed_entry(input int a);
    logic [63:0] mid, msq, num;
    mid = (64'd1 << (TAB_BITS + 1)) + 64'(2 * a + 1);
    msq = mid * mid;
    num = 64'd1 << (TAB_W + 2 * TAB_BITS + 2);
    seed_entry = TAB_W'((num + msq - 64'd1) / msq);
  endfunction

  logic [TAB_W-1:0] seed_tab [TAB_N];
  generate
    for (genvar i = 0; i < TAB_N; i++) begin : g_tab
      assign seed_tab[i] = seed_entry(i);
    end
  endgenerate

  logic [MOD_W:0] xmod;
  assign xmod = {1'b1, den_i[F-1 -: TAB_BITS], ~den_i[F-TAB_BITS-1 -: INV_W]};

  logic             v1, v2, v3, v4;
  logic [SIG_W-1:0] n1, n2, n3, n4, d1, d2, d3;
  logic [TAB_W-1:0] r1;
  logic [MOD_W:0]   m1;
  logic [SEED_F:0]  p0_2, p0_3;
  logic [DP_F:0]    sq3, rcp4;
  logic [2:0]       since_rst;

  logic [PRD_F:0]      seed_prod;
  logic [SQ_F+1:0]     sq_full;
  logic [PW-1:0]       dq_full, fin;
  logic [PW:0]         dq_sum, fine_sum, coarse_sum;
  logic [DP_F+1:0]     dq_r, two_p0, rcp_full;
  logic [SIG_W+1:0]    fine, coarse;
  logic [SIG_W-1:0]    q_next;
  logic                lt_next;

  assign seed_prod  = r1 * m1;
  assign sq_full    = p0_2 * p0_2;
  assign dq_full    = sq3 * d3;
  assign dq_sum     = {1'b0, dq_full} + ((PW+1)'(1) << (F - 1));
  assign dq_r       = dq_sum[F+DP_F+1:F];
  assign two_p0     = {p0_3, {(DP_F-SEED_F+1){1'b0}}};
  assign rcp_full   = two_p0 - dq_r;
  assign fin        = rcp4 * n4;
  assign fine_sum   = {1'b0, fin} + ((PW+1)'(1) << (FIN_F - SIG_W - 1));
  assign coarse_sum = {1'b0, fin} + ((PW+1)'(1) << (FIN_F - SIG_W));
  assign fine       = fine_sum[FIN_F+1:FIN_F-SIG_W];
  assign coarse     = coarse_sum[FIN_F+2:FIN_F-SIG_W+1];

  always_comb begin
    if (fine[SIG_W+1:SIG_W] == 2'b00) begin
      lt_next = 1'b1;
      q_next  = fine[SIG_W-1:0];
    end else if (coarse[SIG_W+1:SIG_W] != 2'b00) begin
      lt_next = 1'b0;
      q_next  = '1;
    end else begin
      lt_next = 1'b0;
      q_next  = coarse[SIG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {v1, v2, v3, v4, out_valid} <= '0;
      {n1, n2, n3, n4, d1, d2, d3} <= '0;
      r1 <= '0;  m1 <= '0;
      p0_2 <= '0; p0_3 <= '0;
      sq3 <= '0; rcp4 <= '0;
      quo_o <= '0; lt_one_o <= 1'b0;
      since_rst <= '0;
    end else begin
      v1 <= in_valid; n1 <= num_i; d1 <= den_i;
      r1 <= seed_tab[den_i[F-1 -: TAB_BITS]];
      m1 <= xmod;
      v2 <= v1; n2 <= n1; d2 <= d1;
      p0_2 <= seed_prod[PRD_F -: SEED_F+1];
      v3 <= v2; n3 <= n2; d3 <= d2; p0_3 <= p0_2;
      sq3 <= sq_full[SQ_F -: DP_F+1];
      v4 <= v3; n4 <= n3;
      rcp4 <= rcp_full[DP_F:0];
      out_valid <= v4;
      quo_o     <= q_next;
      lt_one_o  <= lt_next;
      if (since_rst != 3'd5) since_rst <= since_rst + 3'd1;
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd5) |-> (out_valid == $past(in_valid, 5))); // R4
  AST_QUO_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> quo_o[SIG_W-1]); // R3
  AST_SEED_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> (!p0_2[SEED_F] && p0_2[SEED_F-1])); // R9
  AST_RECIP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    v4 |-> (rcp4[DP_F:DP_F-2] != 3'b000)); // R9
endmodule

// File: tb/tb_nr_sig_div.sv
module tb_nr_sig_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] num_i = '0;
  logic [23:0] den_i = '0;
  logic        out_valid;
  logic [23:0] quo_o;
  logic        lt_one_o;

  nr_sig_div dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .num_i(num_i), .den_i(den_i),
    .out_valid(out_valid), .quo_o(quo_o), .lt_one_o(lt_one_o)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_pass = 0, n_total = 0;
  logic [23:0] qn [0:2047];
  logic [23:0] qd [0:2047];
  int          qc [0:2047];
  int wr = 0, rd = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic check_result(input logic [23:0] n, input logic [23:0] d, input int c0);
    longint ln, ld, lq, err;
    bit near;
    int sc;
    ln = longint'(n); ld = longint'(d); lq = longint'(quo_o);
    near = (ln - ld <= 1) && (ld - ln <= 1);
    chk(cyc - c0 == 5, "R4", "latency", cyc - c0, 5);
    chk(quo_o[23], "R3", "leading bit", quo_o[23], 1);
    if (!near)
      chk(lt_one_o == (n < d), (n < d) ? "R2" : "R1", "flag", lt_one_o, n < d);
    sc = lt_one_o ? 24 : 23;
    err = lq * ld - (ln << sc);
    if (err < 0) err = -err;
    chk(err <= ld, near ? "R8" : (lt_one_o ? "R2" : "R1"), "error vs ulp bound", err, ld);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (rd >= wr) chk(1'b0, "R6", "result without operands", 1, 0);
        else begin
          check_result(qn[rd], qd[rd], qc[rd]);
          rd++;
        end
      end else if (rd < wr && cyc > qc[rd] + 5) begin
        chk(1'b0, "R4", "result missing", 0, 1);
        rd++;
      end
    end
  end

  function automatic logic [23:0] rsig();
    return {1'b1, 23'($urandom)};
  endfunction

  task automatic send(input logic [23:0] n, input logic [23:0] d);
    @(negedge clk);
    in_valid = 1'b1; num_i = n; den_i = d;
    qn[wr] = n; qd[wr] = d; qc[wr] = cyc; wr++;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      num_i = 24'h800000; den_i = 24'h800000;
    end
  endtask

  task automatic drain(input string req);
    idle(8);
    chk(rd == wr, req, "all results returned", rd, wr);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7", "valid in reset", out_valid, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R7", "valid after reset", out_valid, 0);
    end
  endtask

  task automatic t_ge();
    logic [23:0] a, b;
    send(24'hFFFFFF, 24'h800000);
    send(24'hC00000, 24'h800000);
    send(24'hFFFFFF, 24'hFFFFFE);
    for (int i = 0; i < 40; i++) begin
      a = rsig(); b = rsig();
      if (a < b) send(b, a); else send(a, b);
      idle(1);
    end
    drain("R1");
  endtask

  task automatic t_lt();
    logic [23:0] a, b;
    send(24'h800000, 24'hFFFFFF);
    send(24'h800000, 24'hC00000);
    send(24'h800001, 24'hFFFFFF);
    for (int i = 0; i < 40; i++) begin
      a = rsig(); b = rsig();
      if (a < b) send(a, b); else if (a > b) send(b, a);
      idle(1);
    end
    drain("R2");
  endtask

  task automatic t_unity();
    logic [23:0] a;
    send(24'h800000, 24'h800000);
    send(24'hFFFFFF, 24'hFFFFFF);
    for (int i = 0; i < 12; i++) begin
      a = {1'b1, 22'($urandom), 1'b1};
      send(a, a);
      send(a, a + 24'd1);
      send(a + 24'd1, a);
    end
    drain("R8");
  endtask

  task automatic t_segments();
    for (int s = 0; s < 64; s++) begin
      send(rsig(), {1'b1, 6'(s), 17'($urandom)});
      send(rsig(), {1'b1, 6'(s), 17'h00000});
      send(rsig(), {1'b1, 6'(s), 17'h1FFFF});
    end
    drain("R9");
  endtask

  task automatic t_stream();
    int seen0;
    seen0 = rd;
    for (int i = 0; i < 300; i++) send(rsig(), rsig());
    idle(8);
    chk(rd - seen0 == 300, "R5", "back-to-back result count", rd - seen0, 300);
  endtask

  task automatic t_bubble();
    int seen0, sent;
    seen0 = rd; sent = 0;
    for (int i = 0; i < 40; i++) begin
      send(rsig(), rsig());
      sent++;
      idle(1 + (i % 3));
    end
    idle(8);
    chk(rd - seen0 == sent, "R6", "result count with gaps", rd - seen0, sent);
    chk(out_valid == 1'b0, "R6", "valid when idle", out_valid, 0);
  endtask

  initial begin
    t_reset();
    t_ge();
    t_lt();
    t_unity();
    t_segments();
    t_stream();
    t_bubble();
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R4", "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule